// File: doc/BRIEF.md
# LIN Controller CPU Register Bank

This block is the processor-facing register file of a LIN bus controller. A host reaches it through a 4-bit address, an 8-bit bidirectional data bus and active-low select, read and write strobes. The block stores the configuration the serial engine needs: the mode and interrupt-enable bits, the identifier mask and filter, the bit-rate divisor and the byte waiting to be sent. It also shows the host the state the engine reports: received data, buffer occupancy, line activity and error conditions.

The protocol engine is not part of this block. It appears only as single-cycle event inputs: a byte has been received, the transmit byte has been taken, and one error event line per error class. The block turns these events into sticky flags. The error flags and their summary bit clear when the host reads the error status register. The block drives a single level-sensitive interrupt. That line stays high for as long as any enabled cause remains pending. The strobes are taken as synchronous to the block clock.

Top module: `lin_regbank`

## Requirements
- R1: After reset the registers read as follows: control 0xA0, status1 0x03, status2 0x00, mask 0x00, filter 0x00, divisor high 0x00, divisor low 0x02. In addition, irq is 0, slave_mode is 0 and the divisor output is 0x002.
- R2: The register addresses are: mask 6, filter 7, divisor high 8, divisor low 9. Mask and filter read back exactly what was written. Divisor high keeps only bits 3:0 and reads 0 in bits 7:4. The divisor output is {high[3:0], low}, and the mask and filter outputs follow their registers.
- R3: The control register is at address 0. Its bits are: 7 enables the receive-full interrupt, 6 enables the transmit-empty interrupt, 5 enables the error interrupt, 1 is a stored spare bit, and 0 selects slave mode (1) or master mode (0). Bits 4:2 read 0. Bit 0 drives slave_mode and bit 1 drives autobaud.
- R4: A write to address 4 loads tx_byte and clears transmit-empty (status1 bit 1). A tx_taken pulse sets transmit-empty again. Address 4 reads 0x00.
- R5: An rx_evt pulse loads rx_byte into the receive register and clears receive-empty (status1 bit 0). A read of address 5 returns that byte. Receive-empty is set again on the first clock after the read strobe ends.
- R6: An rx_evt pulse that arrives while the receive register is full sets status2 bit 0 (overrun). The new byte is dropped and the register keeps the old byte.
- R7: A pulse on err_evt[k] sets status2 bit k (6 short frame, 5 no response, 4 transmit bit error, 3 framing, 2 identifier parity, 1 checksum, 0 overrun). Any error event also sets status1 bit 3.
- R8: A read of address 3 returns the flags. On the first clock after that read strobe ends, all status2 flags and status1 bit 3 clear. An error event in that same clock cycle is kept.
- R9: irq = (ctrl[7] & !rx_empty) | (ctrl[6] & tx_empty) | (ctrl[5] & error summary). It stays high until the host clears the cause or disables its enable bit.
- R10: The block drives the data bus only while sel_n and rd_n are both low and wr_n is high. At all other times it leaves the bus free for the host.
- R11: Writes to addresses 2, 3 and 5 and to unused addresses change no register.
- R12: Status1 bit 2 reflects the core_idle input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 4 | Register address |
| dbus | inout | 8 | Bidirectional host data bus |
| core_idle | input | 1 | Engine reports that the line is idle |
| rx_evt | input | 1 | One-cycle pulse: a byte has been received |
| rx_byte | input | 8 | Received byte, valid with rx_evt |
| tx_taken | input | 1 | One-cycle pulse: the engine has taken the transmit byte |
| err_evt | input | 7 | One-cycle error event pulses, one per status2 bit |
| irq | output | 1 | Level-sensitive interrupt |
| tx_byte | output | 8 | Transmit data register |
| slave_mode | output | 1 | 1 = slave node, 0 = master node |
| autobaud | output | 1 | Stored spare control bit |
| id_mask | output | 8 | Identifier mask |
| id_filter | output | 8 | Identifier filter |
| divisor | output | 12 | Bit-rate divisor {high nibble, low byte} |

## Verification
Read data is combinational: it is due in the same cycle that select and read go low, so the monitor samples it 1 ns after the bench asserts the strobes. Writes and event pulses take effect at the first rising edge while they are held. Side effects of a read take effect at the first rising edge after the strobe is released. For that reason the bench ends every access and pulse one falling edge later before it samples status bits or irq. The race between a status2 clear and a new error event is driven in that same edge, on purpose.

// File: rtl/lin_reg_pkg.sv
// Package: address map and bit positions shared by the register bank.
// Assumes an 8-bit data bus and 4-bit addresses.
package lin_reg_pkg;
    localparam int A_CTRL  = 0;
    localparam int A_STAT1 = 2;
    localparam int A_STAT2 = 3;
    localparam int A_TXD   = 4;
    localparam int A_RXD   = 5;
    localparam int A_MASK  = 6;
    localparam int A_FILT  = 7;
    localparam int A_DIVH  = 8;
    localparam int A_DIVL  = 9;

    localparam int C_RXIE  = 7;
    localparam int C_TXIE  = 6;
    localparam int C_ERRIE = 5;
    localparam int C_SPARE = 1;
    localparam int C_SLAVE = 0;
    localparam logic [7:0] CTRL_KEEP  = 8'hE3;
    localparam logic [7:0] CTRL_RESET = 8'hA0;

    localparam int S_ERR  = 3;
    localparam int S_IDLE = 2;
    localparam int S_TXE  = 1;
    localparam int S_RXE  = 0;

    localparam int E_OVR  = 0;
endpackage

// File: rtl/lin_bus_if.sv
// Host strobe decoder. It turns the active-low strobes into a write level
// and a one-cycle read-end pulse, and drives the data bus only during a read.
// Assumes the strobes are synchronous to clk.
module lin_bus_if #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    inout  wire  [DW-1:0] dbus,
    input  logic [DW-1:0] rd_val,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_end,
    output logic [AW-1:0] rd_end_addr
);
    logic          rd_act, rd_act_q;
    logic [AW-1:0] addr_q;

    // Classify the current strobe state; a write takes precedence over a read.
    always_comb begin
        rd_act  = !sel_n && !rd_n && wr_n;
        wr_en   = !sel_n && !wr_n;
        wr_addr = addr;
        wr_data = dbus;
    end

    // Drive the bus only while a read is active.
    assign dbus = rd_act ? rd_val : {DW{1'bz}};

    // Remember the read state and its address so that the read end can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            rd_act_q <= rd_act;
            if (rd_act) addr_q <= addr;
        end
    end

    assign rd_end      = rd_act_q && !rd_act;
    assign rd_end_addr = addr_q;

    p_read_end_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_end |=> !rd_end);
endmodule

// File: rtl/lin_cfg_regs.sv
// Configuration registers: control, identifier mask and filter, and divisor.
// Holds what the host writes; only the implemented control bits are stored.
module lin_cfg_regs
    import lin_reg_pkg::*;
#(
    parameter int AW      = 4,
    parameter int DW      = 8,
    parameter int DHW     = 4,
    parameter int DIV_RST = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  ctrl,
    output logic [DW-1:0]  id_mask,
    output logic [DW-1:0]  id_filter,
    output logic [DHW-1:0] div_hi,
    output logic [DW-1:0]  div_lo
);
    // Load whichever configuration register is addressed by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= CTRL_RESET;
            id_mask   <= '0;
            id_filter <= '0;
            div_hi    <= '0;
            div_lo    <= DW'(DIV_RST);
        end else if (wr_en) begin
            case (int'(wr_addr))
                A_CTRL:  ctrl      <= wr_data & CTRL_KEEP;
                A_MASK:  id_mask   <= wr_data;
                A_FILT:  id_filter <= wr_data;
                A_DIVH:  div_hi    <= wr_data[DHW-1:0];
                A_DIVL:  div_lo    <= wr_data;
                default: ;
            endcase
        end
    end

    p_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) == A_CTRL) |=> (ctrl == ($past(wr_data) & CTRL_KEEP)));
    p_div_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(div_lo) && $stable(div_hi));
endmodule

// File: rtl/lin_flag_bank.sv
// Data registers and sticky flags. Engine events set the flags, host reads and
// writes clear them, and an event in the same cycle as a clear wins.
module lin_flag_bank #(
    parameter int DW   = 8,
    parameter int NERR = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_tdr,
    input  logic [DW-1:0]   wr_data,
    input  logic            tx_taken,
    input  logic            rx_evt,
    input  logic [DW-1:0]   rx_byte,
    input  logic [NERR-1:0] err_evt,
    input  logic            rd_rx_end,
    input  logic            rd_st2_end,
    output logic [DW-1:0]   tdr,
    output logic            tx_empty,
    output logic [DW-1:0]   rdr,
    output logic            rx_empty,
    output logic [NERR-1:0] flags,
    output logic            err_sum
);
    logic            rx_full_now, ovr_evt;
    logic [NERR-1:0] set_vec;

    // The receive register counts as full unless the host is emptying it in this cycle.
    always_comb begin
        rx_full_now = !rx_empty && !rd_rx_end;
        ovr_evt     = rx_evt && rx_full_now;
        set_vec     = err_evt;
        set_vec[0]  = err_evt[0] || ovr_evt;
    end

    // Transmit register: a host write fills it, the engine's take empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdr      <= '0;
            tx_empty <= 1'b1;
        end else if (wr_tdr) begin
            tdr      <= wr_data;
            tx_empty <= 1'b0;
        end else if (tx_taken) begin
            tx_empty <= 1'b1;
        end
    end

    // Receive register: load a new byte only when there is room for it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr      <= '0;
            rx_empty <= 1'b1;
        end else if (rx_evt && !rx_full_now) begin
            rdr      <= rx_byte;
            rx_empty <= 1'b0;
        end else if (rd_rx_end) begin
            rx_empty <= 1'b1;
        end
    end

    // One sticky flag per error class; a set wins over a clear in the same cycle.
    for (genvar k = 0; k < NERR; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)              flags[k] <= 1'b0;
            else if (set_vec[k])     flags[k] <= 1'b1;
            else if (rd_st2_end)     flags[k] <= 1'b0;
        end
    end

    // Summary error bit, kept as its own sticky register.
    always_ff @(posedge clk) begin
        if (!rst_n)             err_sum <= 1'b0;
        else if (|set_vec)      err_sum <= 1'b1;
        else if (rd_st2_end)    err_sum <= 1'b0;
    end

    p_sum_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_sum == (|flags));
    p_overrun_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && !rx_empty && !rd_rx_end) |=> $stable(rdr) && flags[0]);
    p_tx_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tdr |=> !tx_empty);
    p_rx_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx_end && !rx_evt) |=> rx_empty);
    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st2_end && !(|err_evt) && !rx_evt) |=> (flags == '0));
endmodule

// File: rtl/lin_regbank.sv
// LIN controller host register bank (top). It ties together the strobe
// decoder, the configuration registers and the flag bank, selects the read
// data and forms the level interrupt. Engine events are single-cycle pulses.
module lin_regbank
    import lin_reg_pkg::*;
#(
    parameter int AW      = 4,
    parameter int DW      = 8,
    parameter int NERR    = 7,
    parameter int DHW     = 4,
    parameter int DIV_RST = 2,
    localparam int DIVW   = DHW + DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [AW-1:0]   addr,
    inout  wire  [DW-1:0]   dbus,
    input  logic            core_idle,
    input  logic            rx_evt,
    input  logic [DW-1:0]   rx_byte,
    input  logic            tx_taken,
    input  logic [NERR-1:0] err_evt,
    output logic            irq,
    output logic [DW-1:0]   tx_byte,
    output logic            slave_mode,
    output logic            autobaud,
    output logic [DW-1:0]   id_mask,
    output logic [DW-1:0]   id_filter,
    output logic [DIVW-1:0] divisor
);
    logic            wr_en, rd_end;
    logic [AW-1:0]   wr_addr, rd_end_addr;
    logic [DW-1:0]   wr_data, rd_val, ctrl, div_lo, rdr;
    logic [DHW-1:0]  div_hi;
    logic            tx_empty, rx_empty, err_sum;
    logic [NERR-1:0] flags;
    logic            wr_tdr, rd_rx_end, rd_st2_end;

    lin_bus_if #(.AW(AW), .DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .dbus(dbus), .rd_val(rd_val), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_end(rd_end),
        .rd_end_addr(rd_end_addr)
    );

    lin_cfg_regs #(.AW(AW), .DW(DW), .DHW(DHW), .DIV_RST(DIV_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .id_mask(id_mask),
        .id_filter(id_filter), .div_hi(div_hi), .div_lo(div_lo)
    );

    // Decode the accesses that have side effects on the data registers and flags.
    always_comb begin
        wr_tdr     = wr_en && int'(wr_addr) == A_TXD;
        rd_rx_end  = rd_end && int'(rd_end_addr) == A_RXD;
        rd_st2_end = rd_end && int'(rd_end_addr) == A_STAT2;
    end

    lin_flag_bank #(.DW(DW), .NERR(NERR)) u_flags (
        .clk(clk), .rst_n(rst_n), .wr_tdr(wr_tdr), .wr_data(wr_data),
        .tx_taken(tx_taken), .rx_evt(rx_evt), .rx_byte(rx_byte),
        .err_evt(err_evt), .rd_rx_end(rd_rx_end), .rd_st2_end(rd_st2_end),
        .tdr(tx_byte), .tx_empty(tx_empty), .rdr(rdr), .rx_empty(rx_empty),
        .flags(flags), .err_sum(err_sum)
    );

    // Read data multiplexer; write-only and unused addresses read as zero.
    always_comb begin
        rd_val = '0;
        case (int'(addr))
            A_CTRL:  rd_val = ctrl;
            A_STAT1: begin
                rd_val[S_ERR]  = err_sum;
                rd_val[S_IDLE] = core_idle;
                rd_val[S_TXE]  = tx_empty;
                rd_val[S_RXE]  = rx_empty;
            end
            A_STAT2: rd_val = DW'(flags);
            A_RXD:   rd_val = rdr;
            A_MASK:  rd_val = id_mask;
            A_FILT:  rd_val = id_filter;
            A_DIVH:  rd_val = DW'(div_hi);
            A_DIVL:  rd_val = div_lo;
            default: rd_val = '0;
        endcase
    end

    // Level interrupt from each enabled cause that is pending.
    always_comb begin
        irq = (ctrl[C_RXIE] && !rx_empty) || (ctrl[C_TXIE] && tx_empty) ||
              (ctrl[C_ERRIE] && err_sum);
    end

    assign slave_mode = ctrl[C_SLAVE];
    assign autobaud   = ctrl[C_SPARE];
    assign divisor    = {div_hi, div_lo};
endmodule

// File: tb/lin_regbank_test.sv
`timescale 1ns/1ps
module lin_regbank_test;
    typedef struct {
        logic [3:0] a;
        logic [7:0] v;
        string      tag;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic sel_n = 1, rd_n = 1, wr_n = 1;
    logic [3:0] addr = 0;
    logic bus_drv = 0;
    logic [7:0] bus_val = 0;
    wire  [7:0] dbus;
    logic core_idle = 0, rx_evt = 0, tx_taken = 0;
    logic [7:0] rx_byte = 0;
    logic [6:0] err_evt = 0;
    logic irq, slave_mode, autobaud;
    logic [7:0] tx_byte, id_mask, id_filter;
    logic [11:0] divisor;

    int total = 0, bad = 0;
    bit finished = 0;
    exp_t q[$];
    event smp;

    assign dbus = bus_drv ? bus_val : 8'hzz;
    always #2.5 clk = ~clk;

    lin_regbank uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .dbus(dbus), .core_idle(core_idle), .rx_evt(rx_evt),
        .rx_byte(rx_byte), .tx_taken(tx_taken), .err_evt(err_evt), .irq(irq),
        .tx_byte(tx_byte), .slave_mode(slave_mode), .autobaud(autobaud),
        .id_mask(id_mask), .id_filter(id_filter), .divisor(divisor)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected read item and compare it with the bus.
    always @(smp) begin
        exp_t it;
        it = q.pop_front();
        check(it.tag, {8'h00, dbus}, {8'h00, it.v});
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] v, input string tag);
        exp_t it;
        it.a = a; it.v = v; it.tag = tag;
        q.push_back(it);
        @(negedge clk); addr = a; sel_n = 0; rd_n = 0;
        #1 -> smp;
        @(negedge clk); sel_n = 1; rd_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; bus_val = v; bus_drv = 1; sel_n = 0; wr_n = 0;
        #1 check("R10 bus free during write", {8'h00, dbus}, {8'h00, v});
        @(negedge clk); sel_n = 1; wr_n = 1; bus_drv = 0;
    endtask

    task automatic rx_pulse(input logic [7:0] b);
        @(negedge clk); rx_byte = b; rx_evt = 1;
        @(negedge clk); rx_evt = 0;
    endtask

    task automatic err_pulse(input logic [6:0] e);
        @(negedge clk); err_evt = e;
        @(negedge clk); err_evt = 0;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {15'h0, irq}, 16'h0);
        check("R1 slave_mode", {15'h0, slave_mode}, 16'h0);
        check("R1 divisor", {4'h0, divisor}, 16'h0002);
        rd(0, 8'hA0, "R1 ctrl");
        rd(2, 8'h03, "R1 stat1");
        rd(3, 8'h00, "R1 stat2");
        rd(6, 8'h00, "R1 mask");
        rd(7, 8'h00, "R1 filter");
        rd(8, 8'h00, "R1 divh");
        rd(9, 8'h02, "R1 divl");
        // R2 configuration registers
        wr(6, 8'hFC); wr(7, 8'h28); wr(8, 8'hF3); wr(9, 8'h0C);
        rd(6, 8'hFC, "R2 mask");
        rd(7, 8'h28, "R2 filter");
        rd(8, 8'h03, "R2 divh nibble");
        rd(9, 8'h0C, "R2 divl");
        check("R2 divisor out", {4'h0, divisor}, 16'h030C);
        check("R2 mask out", {8'h0, id_mask}, 16'h00FC);
        check("R2 filter out", {8'h0, id_filter}, 16'h0028);
        // R3 control layout
        wr(0, 8'hFF);
        rd(0, 8'hE3, "R3 ctrl unused bits");
        check("R3 slave_mode", {15'h0, slave_mode}, 16'h1);
        check("R3 autobaud", {15'h0, autobaud}, 16'h1);
        wr(0, 8'hA1);
        check("R3 autobaud off", {15'h0, autobaud}, 16'h0);
        // R12 idle mirror
        core_idle = 1;
        rd(2, 8'h07, "R12 idle bit");
        // R4 transmit register
        wr(4, 8'h3C);
        check("R4 tx_byte", {8'h0, tx_byte}, 16'h003C);
        rd(2, 8'h05, "R4 tx not empty");
        rd(4, 8'h00, "R4 txd reads zero");
        wr(0, 8'hE1);
        check("R9 no tx irq while full", {15'h0, irq}, 16'h0);
        @(negedge clk); tx_taken = 1; @(negedge clk); tx_taken = 0;
        check("R9 tx empty irq", {15'h0, irq}, 16'h1);
        rd(2, 8'h07, "R4 tx empty again");
        wr(0, 8'hA1);
        check("R9 tx irq disabled", {15'h0, irq}, 16'h0);
        // R5/R6 receive and overrun
        rx_pulse(8'h81);
        check("R9 rx irq", {15'h0, irq}, 16'h1);
        rd(2, 8'h06, "R5 rx full");
        rx_pulse(8'h55);
        rd(2, 8'h0E, "R6 summary after overrun");
        rd(5, 8'h81, "R6 old byte kept");
        rd(2, 8'h0F, "R5 rx empty after read");
        check("R9 irq held by error", {15'h0, irq}, 16'h1);
        rd(3, 8'h01, "R6 overrun flag");
        rd(3, 8'h00, "R8 cleared");
        rd(2, 8'h07, "R8 summary cleared");
        check("R9 irq released", {15'h0, irq}, 16'h0);
        // R7 each error class
        for (int k = 1; k < 7; k++) begin
            err_pulse(7'(1 << k));
            rd(2, 8'h0F, $sformatf("R7 summary bit %0d", k));
            rd(3, 8'(1 << k), $sformatf("R7 flag bit %0d", k));
        end
        // R9 error enable gating
        wr(0, 8'h81);
        err_pulse(7'h10);
        check("R9 error irq gated", {15'h0, irq}, 16'h0);
        wr(0, 8'hA1);
        check("R9 error irq enabled", {15'h0, irq}, 16'h1);
        // R8 set during clear survives
        begin
            exp_t it;
            it.a = 3; it.v = 8'h10; it.tag = "R8 race read";
            q.push_back(it);
            @(negedge clk); addr = 3; sel_n = 0; rd_n = 0;
            #1 -> smp;
            @(negedge clk); sel_n = 1; rd_n = 1; err_evt = 7'h08;
            @(negedge clk); err_evt = 0;
        end
        rd(3, 8'h08, "R8 event during clear kept");
        // R11 writes to read-only and unused addresses
        rx_pulse(8'h42);
        wr(2, 8'hFF); wr(3, 8'hFF); wr(5, 8'hFF); wr(4'hA, 8'hFF);
        rd(3, 8'h00, "R11 stat2 unchanged");
        rd(6, 8'hFC, "R11 mask unchanged");
        rd(9, 8'h0C, "R11 divl unchanged");
        rd(0, 8'hA1, "R11 ctrl unchanged");
        rd(5, 8'h42, "R11 rdr unchanged");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule